// File: doc/BRIEF.md
# Sub-Period PWM Scan Sequencer

This block produces the display timing for a time-multiplexed LED matrix and the PWM on-signals for one red/green/blue output channel. It runs on the grayscale clock. A frame strobe starts one frame, which is made of a configurable number of sub-periods. Each sub-period visits all 32 scan lines in order, and each line gets a segment made of a display window followed by a line-switch window.

For each colour, the grayscale value for the line being shown is not sent as a single pulse per frame. It is spread over as many sub-periods as its per-colour minimum-on-time threshold allows, up to the configured sub-period count. Dark levels therefore stay in a few wide pulses that can still light the LED. Bright levels are spread across the whole frame, which raises the effective refresh rate. An upstream line store provides the grayscale value of the current line. The scan-line index selects the row driver.

Top module: `spwm_scan_seq`

## Requirements
- R1: After reset, and until the first frame strobe, the sequencer is idle. In the idle state, line index and sub-period index are 0, and the line-switch flag and all three enables are low.
- R2: A segment lasts GS display cycles followed by T_SW switch cycles. GS is the 10-bit `cfg_seg_len`, with 0 treated as 1. T_SW is the 4-bit `cfg_swt`. The line-switch flag is high in exactly the switch cycles.
- R3: The line index counts 0 to 31 and advances by one at each segment end. When line 31 wraps, the sub-period index advances by one.
- R4: A value v in the 3-bit `cfg_subp` gives v+1 sub-periods. When the last sub-period ends, the block returns to the idle state of R1 until the next strobe.
- R5: Each colour has a 5-bit threshold t inside `cfg_thresh`: red in bits [4:0], green in [9:5], blue in [14:10]. A threshold of 0 acts as 1. A grayscale value g occupies k = min(n, max(1, ceil(g/t))) sub-periods.
- R6: Each of the first k sub-periods gets floor(g/k) on-cycles per segment. Sub-periods 0 to (g mod k)-1 get one extra cycle each. The enable stays low in sub-periods k and later.
- R7: Within the display window, an enable is high from cycle 0 for its allotted count, in one contiguous run, clipped to GS. A count of 1 gives a one-cycle pulse.
- R8: All enables are low throughout the line-switch window.
- R9: A frame strobe that arrives during a frame restarts the frame. In the next cycle the block is at sub-period 0, line 0, cycle 0.
- R10: A grayscale value of 0 never raises its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that starts a frame |
| cfg_subp | input | 3 | Sub-period count minus one |
| cfg_seg_len | input | 10 | Display cycles per segment (GS) |
| cfg_swt | input | 4 | Line-switch cycles per segment (T_SW) |
| cfg_thresh | input | 15 | Three 5-bit thresholds: red [4:0], green [9:5], blue [14:10] |
| gray_r | input | 16 | Red grayscale value for the current line |
| gray_g | input | 16 | Green grayscale value for the current line |
| gray_b | input | 16 | Blue grayscale value for the current line |
| line_idx | output | 5 | Current scan line |
| line_sw | output | 1 | High during the line-switch window |
| subp_idx | output | 3 | Current sub-period |
| en_r | output | 1 | Red PWM enable |
| en_g | output | 1 | Green PWM enable |
| en_b | output | 1 | Blue PWM enable |

## Verification
The bound checker watches, on every cycle, the rules that hold locally in time. No enable is high while the line-switch flag is high. A zero grayscale value never lights its enable. The line index only steps by one or returns to 0. The sub-period index stays within the configured count. A strobe is always followed by the frame origin. The bench scenarios cover what needs whole-frame bookkeeping. They compare each cycle of complete frames against an independently computed sub-period allocation, covering these cases: thresholds at 0 and at maximum, clipping to GS, single-cycle pulses, zero switch time, the GS-of-0 rule, a restart in mid-frame, and the return to idle after the last sub-period.

// File: rtl/spwm_pkg.sv
// Package: shared sizing constants for the sub-period PWM scan sequencer.
// Assumes three colour channels in the order red, green, blue.
package spwm_pkg;
    localparam int NUM_LINES  = 32;
    localparam int SUBP_BITS  = 3;
    localparam int SEG_BITS   = 10;
    localparam int SW_BITS    = 4;
    localparam int THR_BITS   = 5;
    localparam int GRAY_BITS  = 16;
    localparam int NUM_COLOUR = 3;
endpackage

// File: rtl/spwm_seq_timer.sv
// Module: frame/sub-period/line/cycle counter chain.
// A strobe loads the frame origin. The counters then walk the display
// window and the switch window of every segment, every line and every
// sub-period, and return to idle after the last sub-period.
// Assumes the configuration stays stable while a frame is running.
module spwm_seq_timer #(
    parameter int LINES  = 32,
    parameter int SUBP_W = 3,
    parameter int SEG_W  = 10,
    parameter int SW_W   = 4,
    parameter int LINE_W = $clog2(LINES),
    parameter int CYC_W  = SEG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [SUBP_W-1:0] cfg_subp,
    input  logic [SEG_W-1:0]  cfg_seg_len,
    input  logic [SW_W-1:0]   cfg_swt,
    output logic [LINE_W-1:0] line_idx,
    output logic [SUBP_W-1:0] subp_idx,
    output logic [CYC_W-1:0]  cyc,
    output logic              in_disp,
    output logic              line_sw
);
    logic             active;
    logic [SEG_W-1:0] gs_eff;
    logic [CYC_W-1:0] cyc_last;

    // Segment geometry: GS of zero is read as one display cycle.
    always_comb begin
        gs_eff   = (cfg_seg_len == '0) ? SEG_W'(1) : cfg_seg_len;
        cyc_last = CYC_W'(gs_eff) + CYC_W'(cfg_swt) - CYC_W'(1);
    end

    // Counter chain: cycle within segment, then line, then sub-period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cyc      <= '0;
            line_idx <= '0;
            subp_idx <= '0;
        end else if (frame_start) begin
            active   <= 1'b1;
            cyc      <= '0;
            line_idx <= '0;
            subp_idx <= '0;
        end else if (active) begin
            if (cyc == cyc_last) begin
                cyc <= '0;
                if (line_idx == LINE_W'(LINES - 1)) begin
                    line_idx <= '0;
                    if (subp_idx == cfg_subp) begin
                        active   <= 1'b0;
                        subp_idx <= '0;
                    end else begin
                        subp_idx <= subp_idx + SUBP_W'(1);
                    end
                end else begin
                    line_idx <= line_idx + LINE_W'(1);
                end
            end else begin
                cyc <= cyc + CYC_W'(1);
            end
        end
    end

    // Window decode: display part first, then switch part.
    always_comb begin
        in_disp = active && (cyc < CYC_W'(gs_eff));
        line_sw = active && !in_disp;
    end
endmodule

// File: rtl/spwm_chan_alloc.sv
// Module: one colour's sub-period allocation and enable.
// Computes how many sub-periods carry the grayscale value, the on-count for
// the current sub-period, and the enable for the current display cycle.
// Assumes the grayscale value belongs to the line currently being scanned.
module spwm_chan_alloc #(
    parameter int GRAY_W = 16,
    parameter int THR_W  = 5,
    parameter int SUBP_W = 3,
    parameter int CYC_W  = 11
) (
    input  logic [GRAY_W-1:0] gray,
    input  logic [THR_W-1:0]  thr,
    input  logic [SUBP_W-1:0] cfg_subp,
    input  logic [SUBP_W-1:0] subp_idx,
    input  logic [CYC_W-1:0]  cyc,
    input  logic              in_disp,
    output logic              en
);
    localparam int NW = GRAY_W + 1;
    localparam int KW = SUBP_W + 1;

    logic [THR_W-1:0]  thr_eff;
    logic [KW-1:0]     nsub;
    logic [NW-1:0]     need;
    logic [KW-1:0]     k_use;
    logic [GRAY_W-1:0] base;
    logic [GRAY_W-1:0] rem;
    logic [NW-1:0]     on_cnt;

    // Sub-period count: ceil(g/t), at least one, at most the frame's count.
    always_comb begin
        thr_eff = (thr == '0) ? THR_W'(1) : thr;
        nsub    = {1'b0, cfg_subp} + KW'(1);
        need    = ({1'b0, gray} + NW'(thr_eff) - NW'(1)) / NW'(thr_eff);
        if (need == '0)
            k_use = KW'(1);
        else if (need > NW'(nsub))
            k_use = nsub;
        else
            k_use = need[KW-1:0];
    end

    // Per-sub-period share: floor part plus one for the first remainder slots.
    always_comb begin
        base = gray / GRAY_W'(k_use);
        rem  = gray % GRAY_W'(k_use);
        if (KW'(subp_idx) < k_use)
            on_cnt = {1'b0, base} + NW'(GRAY_W'(subp_idx) < rem);
        else
            on_cnt = '0;
    end

    // Enable: contiguous run from display cycle 0.
    always_comb begin
        en = in_disp && (NW'(cyc) < on_cnt);
    end
endmodule

// File: rtl/spwm_scan_seq.sv
// Module: top of the sub-period PWM scan sequencer.
// Joins the counter chain with one allocation unit per colour.
// Threshold fields: red [4:0], green [9:5], blue [14:10].
// Assumes configuration and grayscale inputs are held steady by the source.
module spwm_scan_seq
    import spwm_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int SUBP_W = SUBP_BITS,
    parameter int SEG_W  = SEG_BITS,
    parameter int SW_W   = SW_BITS,
    parameter int THR_W  = THR_BITS,
    parameter int GRAY_W = GRAY_BITS,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic [SUBP_W-1:0]           cfg_subp,
    input  logic [SEG_W-1:0]            cfg_seg_len,
    input  logic [SW_W-1:0]             cfg_swt,
    input  logic [NUM_COLOUR*THR_W-1:0] cfg_thresh,
    input  logic [GRAY_W-1:0]           gray_r,
    input  logic [GRAY_W-1:0]           gray_g,
    input  logic [GRAY_W-1:0]           gray_b,
    output logic [LINE_W-1:0]           line_idx,
    output logic                        line_sw,
    output logic [SUBP_W-1:0]           subp_idx,
    output logic                        en_r,
    output logic                        en_g,
    output logic                        en_b
);
    localparam int CYC_W = SEG_W + 1;

    logic [CYC_W-1:0]  cyc;
    logic              in_disp;
    logic [GRAY_W-1:0] gray_a [NUM_COLOUR];
    logic              en_a   [NUM_COLOUR];

    // Colour fan-in and fan-out in red, green, blue order.
    always_comb begin
        gray_a[0] = gray_r;
        gray_a[1] = gray_g;
        gray_a[2] = gray_b;
        en_r      = en_a[0];
        en_g      = en_a[1];
        en_b      = en_a[2];
    end

    spwm_seq_timer #(
        .LINES (LINES),
        .SUBP_W(SUBP_W),
        .SEG_W (SEG_W),
        .SW_W  (SW_W),
        .LINE_W(LINE_W),
        .CYC_W (CYC_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cfg_subp   (cfg_subp),
        .cfg_seg_len(cfg_seg_len),
        .cfg_swt    (cfg_swt),
        .line_idx   (line_idx),
        .subp_idx   (subp_idx),
        .cyc        (cyc),
        .in_disp    (in_disp),
        .line_sw    (line_sw)
    );

    for (genvar c = 0; c < NUM_COLOUR; c++) begin : g_chan
        spwm_chan_alloc #(
            .GRAY_W(GRAY_W),
            .THR_W (THR_W),
            .SUBP_W(SUBP_W),
            .CYC_W (CYC_W)
        ) u_alloc (
            .gray    (gray_a[c]),
            .thr     (cfg_thresh[c*THR_W +: THR_W]),
            .cfg_subp(cfg_subp),
            .subp_idx(subp_idx),
            .cyc     (cyc),
            .in_disp (in_disp),
            .en      (en_a[c])
        );
    end
endmodule

// File: rtl/spwm_scan_seq_chk.sv
// Module: assertion checker bound to the scan sequencer top.
// Observes ports only; assumes configuration is stable during a frame.
module spwm_scan_seq_chk
    import spwm_pkg::*;
#(
    parameter int SUBP_W = SUBP_BITS,
    parameter int SEG_W  = SEG_BITS,
    parameter int SW_W   = SW_BITS,
    parameter int THR_W  = THR_BITS,
    parameter int GRAY_W = GRAY_BITS,
    parameter int LINE_W = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frame_start,
    input logic [SUBP_W-1:0]           cfg_subp,
    input logic [SEG_W-1:0]            cfg_seg_len,
    input logic [SW_W-1:0]             cfg_swt,
    input logic [NUM_COLOUR*THR_W-1:0] cfg_thresh,
    input logic [GRAY_W-1:0]           gray_r,
    input logic [GRAY_W-1:0]           gray_g,
    input logic [GRAY_W-1:0]           gray_b,
    input logic [LINE_W-1:0]           line_idx,
    input logic                        line_sw,
    input logic [SUBP_W-1:0]           subp_idx,
    input logic                        en_r,
    input logic                        en_g,
    input logic                        en_b
);
    p_sw_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_sw |-> !(en_r || en_g || en_b));

    p_zero_gray_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_r |-> gray_r != '0) and (en_g |-> gray_g != '0) and (en_b |-> gray_b != '0));

    p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_idx != $past(line_idx)) |->
            (line_idx == '0 || line_idx == $past(line_idx) + LINE_W'(1)));

    p_subp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        subp_idx <= cfg_subp);

    p_strobe_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_idx == '0 && subp_idx == '0 && !line_sw));
endmodule

bind spwm_scan_seq spwm_scan_seq_chk #(
    .SUBP_W(SUBP_W),
    .SEG_W (SEG_W),
    .SW_W  (SW_W),
    .THR_W (THR_W),
    .GRAY_W(GRAY_W),
    .LINE_W(LINE_W)
) u_chk (.*);

// File: tb/spwm_scan_seq_bench.sv
`timescale 1ns/1ps
module spwm_scan_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  cfg_subp = '0;
    logic [9:0]  cfg_seg_len = 10'd4;
    logic [3:0]  cfg_swt = 4'd1;
    logic [14:0] cfg_thresh = '0;
    logic [15:0] gray_r = '0, gray_g = '0, gray_b = '0;
    logic [4:0]  line_idx;
    logic        line_sw;
    logic [2:0]  subp_idx;
    logic        en_r, en_g, en_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spwm_scan_seq u_spwm_scan_seq (.*);

    // Records one comparison and reports a mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // On-cycles per segment for sub-period s, derived from the allocation rules.
    function automatic int exp_on(int g, int t, int n, int s);
        int te = (t == 0) ? 1 : t;
        int k = 1;
        while (k < n && k * te < g) k++;
        if (s >= k) return 0;
        return g / k + ((s < g % k) ? 1 : 0);
    endfunction

    task automatic idle_check(input string req);
        chk(req, "line_idx", int'(line_idx), 0);
        chk(req, "subp_idx", int'(subp_idx), 0);
        chk(req, "line_sw", int'(line_sw), 0);
        chk(req, "enables", int'({en_r, en_g, en_b}), 0);
    endtask

    // Strobes a frame and compares every cycle; stop_after > 0 abandons early.
    task automatic run_frame(input int v, input int gs, input int sw,
                             input int tr, input int tg, input int tb,
                             input int gr, input int gg, input int gb,
                             input int stop_after);
        int gse = (gs == 0) ? 1 : gs;
        int n = v + 1;
        int seen = 0;
        int onr, ong, onb;
        @(negedge clk);
        cfg_subp = 3'(v); cfg_seg_len = 10'(gs); cfg_swt = 4'(sw);
        cfg_thresh = {5'(tb), 5'(tg), 5'(tr)};
        gray_r = 16'(gr); gray_g = 16'(gg); gray_b = 16'(gb);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int s = 0; s < n; s++) begin
            onr = exp_on(gr, tr, n, s);
            ong = exp_on(gg, tg, n, s);
            onb = exp_on(gb, tb, n, s);
            for (int l = 0; l < 32; l++) begin
                for (int c = 0; c < gse + sw; c++) begin
                    if (stop_after > 0 && seen == stop_after) return;
                    chk("R3", "line_idx", int'(line_idx), l);
                    chk("R4", "subp_idx", int'(subp_idx), s);
                    chk("R2", "line_sw", int'(line_sw), (c >= gse) ? 1 : 0);
                    if (c >= gse) begin
                        chk("R8", "enables in switch", int'({en_r, en_g, en_b}), 0);
                    end else begin
                        chk("R6 R7", "en_r", int'(en_r), (c < onr) ? 1 : 0);
                        chk("R5 R7", "en_g", int'(en_g), (c < ong) ? 1 : 0);
                        chk("R6 R7", "en_b", int'(en_b), (c < onb) ? 1 : 0);
                    end
                    seen++;
                    @(negedge clk);
                end
            end
        end
        idle_check("R4");
    endtask

    task automatic t_reset;
        idle_check("R1");
        repeat (3) @(negedge clk);
        idle_check("R1");
    endtask

    // R5 R6 R7: one sub-period, values below, at and above GS, one-cycle pulse.
    task automatic t_single_subp;
        run_frame(0, 4, 2, 1, 1, 1, 1, 4, 9, 0);
    endtask

    // R5 R6: four sub-periods, thresholds 2, 0 (read as 1) and 31, clipping.
    task automatic t_spread;
        run_frame(3, 8, 2, 2, 0, 31, 5, 7, 40, 0);
    endtask

    // R10 R4: zero gray with eight sub-periods and no switch time; idle afterwards.
    task automatic t_zero_gray;
        run_frame(7, 3, 0, 3, 1, 4, 0, 20, 13, 0);
        repeat (5) @(negedge clk);
        idle_check("R4");
    endtask

    // R2: GS of zero behaves as one display cycle.
    task automatic t_gs_zero;
        run_frame(1, 0, 1, 1, 1, 1, 2, 1, 0, 0);
    endtask

    // R9: strobe in mid-frame restarts at the origin.
    task automatic t_restart;
        run_frame(2, 5, 1, 4, 2, 1, 9, 3, 6, 250);
        run_frame(2, 5, 1, 4, 2, 1, 9, 3, 6, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_single_subp();
        t_spread();
        t_zero_gray();
        t_gs_zero();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule